// File: doc/BRIEF.md
# Byte-Masked Burst Memory Core

This block is a word-organised storage core of 18-bit words, split into two 9-bit byte lanes. It has a write port and a read port that run independently of each other. Each port moves a burst of four words per request. A write request names a base address. It then takes one data word per cycle for four cycles, and each word comes with two byte-select bits. A lane whose select bit is low keeps its stored contents. A read request also names a base address. Two cycles after the request is accepted, four words come out on consecutive cycles, marked by a valid strobe.

Each write beat waits one cycle in a staging register before it reaches the array. A read beat that targets the staged location takes the staged byte instead of the array byte. This is done lane by lane, so a partly masked beat is merged with the older stored lane. A read therefore always sees the newest data, including a beat that entered the write port in the cycle just before.

The write port has four states: WR_IDLE, WR_B1, WR_B2 and WR_B3.
- WR_IDLE goes to WR_B1 on an accepted request. With `wr_sel` low, it stays in WR_IDLE.
- The port then steps WR_B1 to WR_B2, WR_B2 to WR_B3, and WR_B3 back to WR_IDLE, with no condition on any input.

The read port has five states: RD_IDLE, RD_CAP0, RD_CAP1, RD_CAP2 and RD_CAP3.
- RD_IDLE goes to RD_CAP0 when `rd_sel` is high and stays in RD_IDLE otherwise.
- The port then steps RD_CAP0 to RD_CAP1, RD_CAP1 to RD_CAP2, and RD_CAP2 to RD_CAP3.
- RD_CAP3 goes to RD_CAP0 when `rd_sel` is high, which starts a back-to-back burst. Otherwise it returns to RD_IDLE.

Top module: `burst_bytemask_ram`

## Requirements
- R1: After synchronous reset (`rst` high), `rd_valid` is low, and both ports are idle and ready to accept a request.
- R2: A write is accepted in a cycle where `wr_sel` is high and the write port is idle. Beat k (k = 0..3) is sampled k cycles after acceptance; beat 0 is sampled in the acceptance cycle itself. Beat k is stored at the base address with its two low bits replaced by k.
- R3: During a write beat, `wr_be[0]` high stores `wr_data[8:0]` into bits 8:0 of the word, and `wr_be[1]` high stores `wr_data[17:9]` into bits 17:9.
- R4: During a write beat, a lane whose `wr_be` bit is low keeps its earlier stored value.
- R5: Once accepted, a write burst always completes all four beats. `wr_sel` and `wr_addr` are ignored during beats 1 to 3, whatever their values. A new write can be accepted no earlier than the cycle after beat 3.
- R6: A read is accepted when `rd_sel` is high and the read port is idle, or when it is in the last capture cycle of the previous burst. Beat k reads the base address with its two low bits replaced by k.
- R7: For a read accepted in cycle R, `rd_valid` is high in cycles R+2 to R+5, and beat k appears on `rd_data` in cycle R+2+k. `rd_valid` is low in every cycle that does not belong to an accepted burst.
- R8: Read beat k returns the word as updated by every write beat sampled in any cycle up to and including cycle R+k. This includes a beat sampled in the cycle just before that beat's capture.
- R9: Forwarding from a beat that has not yet been committed is decided per lane. A masked lane returns the older stored value, and an enabled lane returns the new data.
- R10: A read accepted in the last capture cycle of the previous burst produces eight consecutive valid beats, with no gap between the two bursts.
- R11: A high `rd_sel` in the RD_CAP0 to RD_CAP2 cycles of a read in progress is ignored. It does not change the addresses or the number of beats returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_sel | input | 1 | Write request, sampled only while the write port is idle |
| wr_addr | input | ADDR_W | Write base address |
| wr_data | input | BYTE_W*NBYTES | Write data for the current beat |
| wr_be | input | NBYTES | Per-lane write enables for the current beat |
| rd_sel | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read base address |
| rd_data | output | BYTE_W*NBYTES | Read data beat |
| rd_valid | output | 1 | High while `rd_data` carries a read beat |

## Verification
The hardest case to reach from the ports is a read beat that is captured exactly one cycle after a write beat to the same word was sampled. On top of that, the write beat must have only one lane enabled, so that the returned word is half forwarded and half taken from the array. The stimulus reaches this case by accepting a read and a write to the same base address in the same cycle. Every read beat then lines up with the staged write beat, and the lane masks are varied within the burst. A long random run then confines both ports to four base blocks, so that partial overlaps at other offsets also occur. Every returned word is compared with a model that applies write beats in the cycle they are sampled.

// File: rtl/bbr_pkg.sv
package bbr_pkg;

    // Burst length is fixed at four beats; the beat index replaces the low address bits.
    localparam int BURST_LEN = 4;
    localparam int BEAT_W    = $clog2(BURST_LEN);

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_B1,
        WR_B2,
        WR_B3
    } wr_state_t;

    typedef enum logic [2:0] {
        RD_IDLE,
        RD_CAP0,
        RD_CAP1,
        RD_CAP2,
        RD_CAP3
    } rd_state_t;

endpackage

// File: rtl/bbr_wr_ctrl.sv
module bbr_wr_ctrl
    import bbr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 18,
    parameter int NBYTES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NBYTES-1:0] wr_be,
    output logic              stg_vld,
    output logic [ADDR_W-1:0] stg_addr,
    output logic [DATA_W-1:0] stg_data,
    output logic [NBYTES-1:0] stg_be,
    output wr_state_t         wr_state
);

    localparam int HI_W = ADDR_W - BEAT_W;

    wr_state_t         state_q;
    wr_state_t         state_d;
    logic [HI_W-1:0]   base_q;
    logic [HI_W-1:0]   hi;
    logic [BEAT_W-1:0] beat;
    logic              take;
    logic              accept;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= WR_IDLE;
        else     state_q <= state_d;
    end

    // Next state and beat decode
    always_comb begin
        state_d = state_q;
        beat    = '0;
        take    = 1'b1;
        unique case (state_q)
            WR_IDLE: begin
                take = wr_sel;
                if (wr_sel) state_d = WR_B1;
            end
            WR_B1: begin
                beat    = BEAT_W'(1);
                state_d = WR_B2;
            end
            WR_B2: begin
                beat    = BEAT_W'(2);
                state_d = WR_B3;
            end
            WR_B3: begin
                beat    = BEAT_W'(3);
                state_d = WR_IDLE;
            end
            default: state_d = WR_IDLE;
        endcase
        accept = (state_q == WR_IDLE) && wr_sel;
        hi     = (state_q == WR_IDLE) ? wr_addr[ADDR_W-1:BEAT_W] : base_q;
    end

    // Outputs: staging register and burst base
    always_ff @(posedge clk) begin
        if (rst) begin
            stg_vld  <= 1'b0;
            stg_addr <= '0;
            stg_data <= '0;
            stg_be   <= '0;
            base_q   <= '0;
        end else begin
            stg_vld <= take;
            if (take) begin
                stg_addr <= {hi, beat};
                stg_data <= wr_data;
                stg_be   <= wr_be;
            end
            if (accept) base_q <= wr_addr[ADDR_W-1:BEAT_W];
        end
    end

    assign wr_state = state_q;

endmodule

// File: rtl/bbr_rd_ctrl.sv
module bbr_rd_ctrl
    import bbr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              cap_en,
    output logic [ADDR_W-1:0] cap_addr,
    output rd_state_t         rd_state
);

    localparam int HI_W = ADDR_W - BEAT_W;

    rd_state_t         state_q;
    rd_state_t         state_d;
    logic [HI_W-1:0]   base_q;
    logic [BEAT_W-1:0] beat;
    logic              accept;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= RD_IDLE;
        else     state_q <= state_d;
    end

    // Next state, accept window and beat decode
    always_comb begin
        state_d = state_q;
        beat    = '0;
        cap_en  = 1'b1;
        accept  = 1'b0;
        unique case (state_q)
            RD_IDLE: begin
                cap_en = 1'b0;
                accept = rd_sel;
                if (rd_sel) state_d = RD_CAP0;
            end
            RD_CAP0: state_d = RD_CAP1;
            RD_CAP1: begin
                beat    = BEAT_W'(1);
                state_d = RD_CAP2;
            end
            RD_CAP2: begin
                beat    = BEAT_W'(2);
                state_d = RD_CAP3;
            end
            RD_CAP3: begin
                beat    = BEAT_W'(3);
                accept  = rd_sel;
                state_d = rd_sel ? RD_CAP0 : RD_IDLE;
            end
            default: begin
                cap_en  = 1'b0;
                state_d = RD_IDLE;
            end
        endcase
        cap_addr = {base_q, beat};
    end

    // Burst base register
    always_ff @(posedge clk) begin
        if (rst)         base_q <= '0;
        else if (accept) base_q <= rd_addr[ADDR_W-1:BEAT_W];
    end

    assign rd_state = state_q;

endmodule

// File: rtl/bbr_bank.sv
module bbr_bank #(
    parameter int ADDR_W = 6,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     stg_vld,
    input  logic [ADDR_W-1:0]        stg_addr,
    input  logic [BYTE_W*NBYTES-1:0] stg_data,
    input  logic [NBYTES-1:0]        stg_be,
    input  logic                     cap_en,
    input  logic [ADDR_W-1:0]        cap_addr,
    output logic [BYTE_W*NBYTES-1:0] rd_data,
    output logic                     rd_valid
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = BYTE_W * NBYTES;

    logic [DATA_W-1:0] merged;
    logic              same_word;

    assign same_word = stg_vld && (stg_addr == cap_addr);

    // One storage lane per byte; forwarding decided lane by lane
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];
        logic              fwd;

        always_ff @(posedge clk) begin
            if (stg_vld && stg_be[g])
                lane_mem[stg_addr] <= stg_data[g*BYTE_W +: BYTE_W];
        end

        assign fwd = same_word && stg_be[g];
        assign merged[g*BYTE_W +: BYTE_W] =
            fwd ? stg_data[g*BYTE_W +: BYTE_W] : lane_mem[cap_addr];
    end

    // Output register: one cycle after capture
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= cap_en;
            if (cap_en) rd_data <= merged;
        end
    end

endmodule

// File: rtl/burst_bytemask_ram.sv
module burst_bytemask_ram
    import bbr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_sel,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [BYTE_W*NBYTES-1:0] wr_data,
    input  logic [NBYTES-1:0]        wr_be,
    input  logic                     rd_sel,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [BYTE_W*NBYTES-1:0] rd_data,
    output logic                     rd_valid
);

    localparam int DATA_W = BYTE_W * NBYTES;

    logic              stg_vld;
    logic [ADDR_W-1:0] stg_addr;
    logic [DATA_W-1:0] stg_data;
    logic [NBYTES-1:0] stg_be;
    logic              cap_en;
    logic [ADDR_W-1:0] cap_addr;
    wr_state_t         wr_state;
    rd_state_t         rd_state;

    bbr_wr_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NBYTES (NBYTES)
    ) i_wr (
        .clk      (clk),
        .rst      (rst),
        .wr_sel   (wr_sel),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_be    (wr_be),
        .stg_vld  (stg_vld),
        .stg_addr (stg_addr),
        .stg_data (stg_data),
        .stg_be   (stg_be),
        .wr_state (wr_state)
    );

    bbr_rd_ctrl #(
        .ADDR_W (ADDR_W)
    ) i_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_sel   (rd_sel),
        .rd_addr  (rd_addr),
        .cap_en   (cap_en),
        .cap_addr (cap_addr),
        .rd_state (rd_state)
    );

    bbr_bank #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES)
    ) i_bank (
        .clk      (clk),
        .rst      (rst),
        .stg_vld  (stg_vld),
        .stg_addr (stg_addr),
        .stg_data (stg_data),
        .stg_be   (stg_be),
        .cap_en   (cap_en),
        .cap_addr (cap_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/bbr_chk.sv
module bbr_chk
    import bbr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_sel,
    input logic                     rd_sel,
    input logic                     rd_valid,
    input logic [BYTE_W*NBYTES-1:0] rd_data,
    input wr_state_t                wr_state,
    input rd_state_t                rd_state,
    input logic                     stg_vld,
    input logic [ADDR_W-1:0]        stg_addr,
    input logic [BYTE_W*NBYTES-1:0] stg_data,
    input logic [NBYTES-1:0]        stg_be,
    input logic                     cap_en,
    input logic [ADDR_W-1:0]        cap_addr
);

    // R7: an idle read port yields no valid beat in the next cycle
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_state == RD_IDLE) |=> !rd_valid);

    // R7: first beat appears two cycles after acceptance from idle
    p_two_cycle_lat_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_sel && rd_state == RD_IDLE) |=> ##1 rd_valid);

    // R7: every run of valid beats lasts at least four cycles
    p_four_beats_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |=> rd_valid ##1 rd_valid ##1 rd_valid);

    // R5: an accepted write stages four beats regardless of wr_sel afterwards
    p_burst_completes_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && wr_state == WR_IDLE) |=> stg_vld ##1 stg_vld ##1 stg_vld ##1 stg_vld);

    // R9: an enabled low lane of the staged beat is forwarded to the read
    p_fwd_low_lane_r9: assert property (@(posedge clk) disable iff (rst)
        (cap_en && stg_vld && stg_be[0] && cap_addr == stg_addr)
        |=> rd_data[BYTE_W-1:0] == $past(stg_data[BYTE_W-1:0]));

    // R9: an enabled high lane of the staged beat is forwarded to the read
    p_fwd_high_lane_r9: assert property (@(posedge clk) disable iff (rst)
        (cap_en && stg_vld && stg_be[NBYTES-1] && cap_addr == stg_addr)
        |=> rd_data[BYTE_W*NBYTES-1 -: BYTE_W] == $past(stg_data[BYTE_W*NBYTES-1 -: BYTE_W]));

endmodule

bind burst_bytemask_ram bbr_chk #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .NBYTES (NBYTES)
) i_bbr_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_sel   (wr_sel),
    .rd_sel   (rd_sel),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .wr_state (wr_state),
    .rd_state (rd_state),
    .stg_vld  (stg_vld),
    .stg_addr (stg_addr),
    .stg_data (stg_data),
    .stg_be   (stg_be),
    .cap_en   (cap_en),
    .cap_addr (cap_addr)
);

// File: tb/test_burst_bytemask_ram.sv
module test_burst_bytemask_ram;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_sel = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    wr_be = '0;
    logic          rd_sel = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_bytemask_ram i_burst_bytemask_ram (
        .clk      (clk),
        .rst      (rst),
        .wr_sel   (wr_sel),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_be    (wr_be),
        .rd_sel   (rd_sel),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // Reference model: word store plus port progress
    logic [DW-1:0] model [1<<AW];
    int            wbeat = 0;      // 0 idle, else index of next write beat
    logic [AW-3:0] wbase = '0;
    int            rphase = 0;     // 0 idle, 1..4 capture of beat 0..3
    logic [AW-3:0] rbase = '0;
    logic          exp_v = 1'b0;
    logic [DW-1:0] exp_d = '0;

    // R3/R4: lane 0 is bits 8:0, lane 1 is bits 17:9
    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [1:0] be);
        logic [DW-1:0] r;
        r       = old_w;
        if (be[0]) r[8:0]  = new_w[8:0];
        if (be[1]) r[17:9] = new_w[17:9];
        return r;
    endfunction

    task automatic cyc(input logic ws, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                       input logic [1:0] wbe, input logic rs, input logic [AW-1:0] ra);
        logic [AW-1:0] a;
        @(negedge clk);
        n_chk++;
        if (rd_valid !== exp_v) begin
            n_bad++;
            $display("FAIL %s rd_valid act=%b exp=%b", cur_req, rd_valid, exp_v);
        end
        if (exp_v) begin
            n_chk++;
            if (rd_data !== exp_d) begin
                n_bad++;
                $display("FAIL %s rd_data act=%h exp=%h", cur_req, rd_data, exp_d);
            end
        end
        wr_sel = ws; wr_addr = wa; wr_data = wd; wr_be = wbe;
        rd_sel = rs; rd_addr = ra;
        // read capture sees all write beats sampled before this cycle
        if (rphase != 0) begin
            a     = {rbase, 2'(rphase - 1)};
            exp_d = model[a];
            exp_v = 1'b1;
        end else begin
            exp_v = 1'b0;
        end
        if (rs && (rphase == 0 || rphase == 4)) begin
            rbase  = ra[AW-1:2];
            rphase = 1;
        end else if (rphase == 4) begin
            rphase = 0;
        end else if (rphase != 0) begin
            rphase++;
        end
        if (wbeat == 0) begin
            if (ws) begin
                wbase    = wa[AW-1:2];
                a        = {wbase, 2'd0};
                model[a] = merge(model[a], wd, wbe);
                wbeat    = 1;
            end
        end else begin
            a        = {wbase, 2'(wbeat)};
            model[a] = merge(model[a], wd, wbe);
            wbeat    = (wbeat == 3) ? 0 : wbeat + 1;
        end
    endtask

    // Write burst; bes holds the per-beat lane enables, beat k at bes[2k+1:2k]
    task automatic wr_burst(input logic [AW-1:0] a, input logic [7:0] bes, input logic hold,
                            input logic rs, input logic [AW-1:0] ra);
        cyc(1'b1, a, DW'($urandom), bes[1:0], rs, ra);
        for (int k = 1; k < 4; k++)
            cyc(hold, AW'($urandom), DW'($urandom), bes[2*k +: 2], 1'b0, '0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, 2'b00, 1'b0, '0);
    endtask

    task automatic rd_one(input logic [AW-1:0] a);
        cyc(1'b0, '0, '0, 2'b00, 1'b1, a);
        idle(6);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < (1<<AW); i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        idle(2);

        // R2: fill every word with full-lane bursts, wr_sel dropped mid-burst
        cur_req = "R2";
        for (int b = 0; b < (1<<(AW-2)); b++) wr_burst(AW'(b*4), 8'hFF, 1'b0, 1'b0, '0);
        idle(2);
        // R6/R7: isolated reads of every block
        cur_req = "R6";
        for (int b = 0; b < (1<<(AW-2)); b++) rd_one(AW'(b*4 + 1));

        // R10: rd_sel held high, bursts chain through the last capture cycle
        cur_req = "R10";
        for (int i = 0; i < 16; i++) cyc(1'b0, '0, '0, 2'b00, 1'b1, AW'((i/4)*4));
        idle(6);

        // R3: mixed lane enables across the burst (11,10,01,11)
        cur_req = "R3";
        wr_burst(AW'(20), 8'b11_01_10_11, 1'b0, 1'b0, '0);
        rd_one(AW'(20));
        // R4: all lanes masked, word must keep earlier contents
        cur_req = "R4";
        wr_burst(AW'(24), 8'b00_00_00_00, 1'b0, 1'b0, '0);
        rd_one(AW'(24));

        // R5: wr_sel held high with foreign addresses during beats 1..3
        cur_req = "R5";
        wr_burst(AW'(28), 8'hFF, 1'b1, 1'b0, '0);
        cyc(1'b0, '0, '0, 2'b00, 1'b0, '0);
        rd_one(AW'(28));
        for (int b = 0; b < (1<<(AW-2)); b++) rd_one(AW'(b*4));

        // R8: read and write of the same block accepted together, full lanes
        cur_req = "R8";
        wr_burst(AW'(8), 8'hFF, 1'b0, 1'b1, AW'(8));
        idle(6);
        // R9: same alignment with partial lanes, forwarding merges per lane
        cur_req = "R9";
        wr_burst(AW'(12), 8'b01_10_00_01, 1'b0, 1'b1, AW'(12));
        idle(6);
        wr_burst(AW'(12), 8'b10_01_11_10, 1'b0, 1'b1, AW'(12));
        idle(6);

        // R11: rd_sel pulses in CAP0..CAP2 with other addresses are ignored
        cur_req = "R11";
        cyc(1'b0, '0, '0, 2'b00, 1'b1, AW'(32));
        for (int i = 0; i < 3; i++) cyc(1'b0, '0, '0, 2'b00, 1'b1, AW'(48));
        idle(6);

        // R8: random traffic confined to four blocks
        cur_req = "R8";
        for (int i = 0; i < 3000; i++)
            cyc(($urandom % 3) == 0, AW'($urandom % 16), DW'($urandom), 2'($urandom),
                ($urandom % 3) == 0, AW'($urandom % 16));
        idle(8);

        finish_run();
    end

endmodule